// File: doc/BRIEF.md
# Keyboard Wakeup and External Interrupt Combiner

This block gathers the keyboard column inputs and a small set of external interrupt pins. From them it forms a wake request for the power-management sequencer and the masked normal and fast interrupt requests for the processor. All pins are asynchronous and active high. Each pin passes through a two-stage synchronizer before any logic uses it. The configuration inputs (direct-wake enable, six-column mode, the mask bits and the current power state) are registered once. A synchronous active-high reset clears them to zero.

The keyboard term is the OR of the active port columns. In eight-column mode all eight columns count. In six-column mode only columns 5:0 count, and columns 7:6 are handed out as general-purpose inputs. Direct-wake mode lets a keypress wake the device even when the keyboard interrupt is masked. In that case no keyboard interrupt reaches the processor, so execution simply resumes. The two general interrupt pins and the fast-interrupt pin go straight into the status vector with no filtering. The media-change pin is filtered by the low-rate sampling tick before its status bit moves.

Top module: `kbwake_irq`

## Requirements
- R1: With `direct_wake_en` at 0, a keypress raises `wake_req` only when the keyboard mask bit `irq_mask[0]` is 1.
- R2: With `direct_wake_en` at 1, a keypress raises `wake_req` in a low-power state whatever the value of `irq_mask[0]`.
- R3: `irq_req` rises for a keypress only when `irq_mask[0]` is 1, including in direct-wake mode.
- R4: With `six_col_mode` at 0, a high level on any of the eight columns sets `raw_status[0]`. `six_col_mode` reads 0 after reset.
- R5: With `six_col_mode` at 1, columns 7:6 have no effect on `raw_status[0]` or `wake_req`, and `key_gpio[1:0]` carries the synchronized columns 7:6. In eight-column mode `key_gpio` is 0.
- R6: The unfiltered pins map into status as follows: `ext_irq_pin[0]` to bit 1, `ext_irq_pin[1]` to bit 2, `fiq_pin` to bit 4. A change on one of these pins appears in `raw_status` on the third rising clock edge after it is applied, and not on the second.
- R7: `raw_status[3]` (media change) sets only after `media_pin` is seen high on two consecutive `tick_16k` samples. It clears only after two consecutive low samples. A lone differing sample leaves it unchanged.
- R8: `irq_req` is the OR over status bits 3:0, each ANDed with the matching `irq_mask` bit. `fiq_req` is `raw_status[4] & irq_mask[4]` and nothing else.
- R9: `wake_req` can be 1 only when `pwr_state` is idle (2'b01) or standby (2'b10). Run (2'b00) and the unused code 2'b11 keep it at 0. In a low-power state it is the OR of every masked-in source and the direct-wake keyboard term.
- R10: During and right after reset, `wake_req`, `irq_req`, `fiq_req`, `raw_status` and `key_gpio` are all 0, even with keys pressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_cols | input | 8 | Keyboard column inputs, asynchronous |
| direct_wake_en | input | 1 | Keypress wakes regardless of keyboard mask |
| six_col_mode | input | 1 | 1: only columns 5:0 form the keyboard term |
| irq_mask | input | 5 | Per-source enable: 0 key, 1-2 ext, 3 media, 4 fast |
| fiq_pin | input | 1 | Fast interrupt pin, asynchronous |
| ext_irq_pin | input | 2 | General external interrupt pins, asynchronous |
| media_pin | input | 1 | Media-change pin, asynchronous, filtered |
| tick_16k | input | 1 | One-cycle sampling strobe for the media filter, synchronous to clk |
| pwr_state | input | 2 | 00 run, 01 idle, 10 standby, 11 unused |
| wake_req | output | 1 | Wake request to the power sequencer |
| irq_req | output | 1 | Masked normal interrupt request |
| fiq_req | output | 1 | Masked fast interrupt request |
| raw_status | output | 5 | Unmasked source status |
| key_gpio | output | 2 | Columns 7:6 released in six-column mode |

## Verification
A table of vectors crosses the keyboard term with the mask bit, direct-wake enable and power state. This separates wake-without-interrupt from wake-with-interrupt and from no wake at all. Single presses on column 7 and on column 5 under both column modes show whether the top columns are cut out and routed to the general-purpose outputs. Each normal and fast source is tried alone, with and without its mask bit, to confirm that it reaches only its own request. Directed sequences then measure the three-edge pin latency and drive the media filter with one-sample glitches in both directions and with two-sample runs.

// File: rtl/kbw_pkg.sv
package kbw_pkg;

    typedef enum logic [1:0] {
        PWR_RUN     = 2'b00,
        PWR_IDLE    = 2'b01,
        PWR_STANDBY = 2'b10,
        PWR_RSVD    = 2'b11
    } pwr_e;

    localparam int SRC_KEY = 0;

endpackage

// File: rtl/kbw_sync.sv
module kbw_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] ff_d, ff_q;

    always_comb begin
        ff_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            ff_d[i] = ff_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ff_q <= '0;
        else     ff_q <= ff_d;
    end

    assign dout = ff_q[STAGES-1];

endmodule

// File: rtl/kbw_deglitch.sv
module kbw_deglitch (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic din,
    output logic level
);

    typedef struct packed {
        logic prev;
        logic level;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (sample_en) begin
            flt_d.prev = din;
            if (din && flt_q.prev)        flt_d.level = 1'b1;
            else if (!din && !flt_q.prev) flt_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flt_q <= '0;
        else     flt_q <= flt_d;
    end

    assign level = flt_q.level;

    // R7: the filtered level only moves on a sampling strobe
    a_r7_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        (flt_q.level != $past(flt_q.level)) |-> $past(sample_en));

endmodule

// File: rtl/kbw_key_merge.sv
module kbw_key_merge #(
    parameter int KEY_W = 8,
    parameter int LOW_W = 6
) (
    input  logic [KEY_W-1:0]       keys,
    input  logic                   six_mode,
    output logic                   any_key,
    output logic [KEY_W-LOW_W-1:0] gpio
);

    localparam int HI_W = KEY_W - LOW_W;

    logic [KEY_W-1:0] active_mask;

    generate
        for (genvar g = 0; g < KEY_W; g++) begin : g_col
            if (g < LOW_W) begin : g_low
                assign active_mask[g] = 1'b1;
            end else begin : g_high
                assign active_mask[g] = !six_mode;
            end
        end
    endgenerate

    assign any_key = |(keys & active_mask);
    assign gpio    = six_mode ? keys[KEY_W-1:LOW_W] : {HI_W{1'b0}};

endmodule

// File: rtl/kbwake_irq.sv
module kbwake_irq
    import kbw_pkg::*;
#(
    parameter int KEY_W       = 8,
    parameter int KEY_LOW_W   = 6,
    parameter int EXT_N       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [KEY_W-1:0]           key_cols,
    input  logic                       direct_wake_en,
    input  logic                       six_col_mode,
    input  logic [EXT_N+2:0]           irq_mask,
    input  logic                       fiq_pin,
    input  logic [EXT_N-1:0]           ext_irq_pin,
    input  logic                       media_pin,
    input  logic                       tick_16k,
    input  logic [1:0]                 pwr_state,
    output logic                       wake_req,
    output logic                       irq_req,
    output logic                       fiq_req,
    output logic [EXT_N+2:0]           raw_status,
    output logic [KEY_W-KEY_LOW_W-1:0] key_gpio
);

    localparam int NSRC      = EXT_N + 3;
    localparam int IDX_MEDIA = EXT_N + 1;
    localparam int IDX_FIQ   = EXT_N + 2;
    localparam int PIN_W     = KEY_W + EXT_N + 2;

    logic [PIN_W-1:0]       pins_s;
    logic [KEY_W-1:0]       keys_s;
    logic [EXT_N-1:0]       ext_s;
    logic                   media_s;
    logic                   fiq_s;
    logic                   key_any;
    logic                   media_lvl;

    typedef struct packed {
        logic            dw;
        logic            six;
        logic [NSRC-1:0] mask;
        pwr_e            pwr;
        logic [NSRC-1:0] status;
    } st_t;

    st_t st_d, st_q;

    kbw_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({fiq_pin, media_pin, ext_irq_pin, key_cols}),
        .dout (pins_s)
    );

    assign keys_s  = pins_s[KEY_W-1:0];
    assign ext_s   = pins_s[KEY_W+EXT_N-1:KEY_W];
    assign media_s = pins_s[KEY_W+EXT_N];
    assign fiq_s   = pins_s[KEY_W+EXT_N+1];

    kbw_key_merge #(.KEY_W(KEY_W), .LOW_W(KEY_LOW_W)) u_merge (
        .keys     (keys_s),
        .six_mode (st_q.six),
        .any_key  (key_any),
        .gpio     (key_gpio)
    );

    kbw_deglitch u_media (
        .clk       (clk),
        .rst       (rst),
        .sample_en (tick_16k),
        .din       (media_s),
        .level     (media_lvl)
    );

    always_comb begin
        st_d        = st_q;
        st_d.dw     = direct_wake_en;
        st_d.six    = six_col_mode;
        st_d.mask   = irq_mask;
        st_d.pwr    = pwr_e'(pwr_state);
        st_d.status = {fiq_s, media_lvl, ext_s, key_any};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    logic [NSRC-1:0] masked;
    logic            low_power;

    assign masked     = st_q.status & st_q.mask;
    assign low_power  = (st_q.pwr == PWR_IDLE) || (st_q.pwr == PWR_STANDBY);
    assign irq_req    = |masked[IDX_MEDIA:0];
    assign fiq_req    = masked[IDX_FIQ];
    assign wake_req   = low_power && ((|masked) || (st_q.dw && st_q.status[SRC_KEY]));
    assign raw_status = st_q.status;

    // R9: no wake request while running
    a_r9_wake_lowpower: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (st_q.pwr == PWR_IDLE || st_q.pwr == PWR_STANDBY));

    // R2: direct-wake keypress in low power always wakes
    a_r2_direct_wake: assert property (@(posedge clk) disable iff (rst)
        (st_q.dw && raw_status[SRC_KEY] && low_power) |-> wake_req);

    // R8: fast request needs its own status bit
    a_r8_fiq_source: assert property (@(posedge clk) disable iff (rst)
        fiq_req |-> raw_status[IDX_FIQ]);

    // R8: normal request needs some normal status bit
    a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (|raw_status[IDX_MEDIA:0]));

    // R5: general-purpose outputs idle in eight-column mode
    a_r5_gpio_idle: assert property (@(posedge clk) disable iff (rst)
        !st_q.six |-> (key_gpio == '0));

    // R7: media status follows a strobe two edges earlier
    a_r7_media_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_status[IDX_MEDIA]) |-> $past(tick_16k, 2));

    // R10: reset leaves status clear
    a_r10_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (raw_status == '0 && !wake_req && !irq_req && !fiq_req));

endmodule

// File: tb/kbwake_irq_bench.sv
`timescale 1ns/1ps
module kbwake_irq_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] key_cols;
    logic       direct_wake_en, six_col_mode;
    logic [4:0] irq_mask;
    logic       fiq_pin;
    logic [1:0] ext_irq_pin;
    logic       media_pin, tick_16k;
    logic [1:0] pwr_state;
    logic       wake_req, irq_req, fiq_req;
    logic [4:0] raw_status;
    logic [1:0] key_gpio;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    kbwake_irq u_kbwake_irq (
        .clk(clk), .rst(rst), .key_cols(key_cols),
        .direct_wake_en(direct_wake_en), .six_col_mode(six_col_mode),
        .irq_mask(irq_mask), .fiq_pin(fiq_pin), .ext_irq_pin(ext_irq_pin),
        .media_pin(media_pin), .tick_16k(tick_16k), .pwr_state(pwr_state),
        .wake_req(wake_req), .irq_req(irq_req), .fiq_req(fiq_req),
        .raw_status(raw_status), .key_gpio(key_gpio)
    );

    // {keys, dw, six, mask, fiq, ext, pwr, e_wake, e_irq, e_fiq, e_stat, e_gpio}
    localparam int NV = 14;
    localparam logic [29:0] VEC [NV] = '{
        {8'h01,1'b0,1'b0,5'b00001,1'b0,2'b00,2'b01, 1'b1,1'b1,1'b0,5'b00001,2'b00},
        {8'h01,1'b0,1'b0,5'b00000,1'b0,2'b00,2'b01, 1'b0,1'b0,1'b0,5'b00001,2'b00},
        {8'h01,1'b1,1'b0,5'b00000,1'b0,2'b00,2'b10, 1'b1,1'b0,1'b0,5'b00001,2'b00},
        {8'h01,1'b1,1'b0,5'b00001,1'b0,2'b00,2'b10, 1'b1,1'b1,1'b0,5'b00001,2'b00},
        {8'h80,1'b0,1'b0,5'b00001,1'b0,2'b00,2'b01, 1'b1,1'b1,1'b0,5'b00001,2'b00},
        {8'h80,1'b0,1'b1,5'b00001,1'b0,2'b00,2'b01, 1'b0,1'b0,1'b0,5'b00000,2'b10},
        {8'hC0,1'b1,1'b1,5'b00000,1'b0,2'b00,2'b01, 1'b0,1'b0,1'b0,5'b00000,2'b11},
        {8'h20,1'b0,1'b1,5'b00001,1'b0,2'b00,2'b01, 1'b1,1'b1,1'b0,5'b00001,2'b00},
        {8'h00,1'b0,1'b0,5'b00010,1'b0,2'b01,2'b00, 1'b0,1'b1,1'b0,5'b00010,2'b00},
        {8'h00,1'b0,1'b0,5'b00010,1'b0,2'b10,2'b01, 1'b0,1'b0,1'b0,5'b00100,2'b00},
        {8'h00,1'b0,1'b0,5'b10000,1'b1,2'b00,2'b01, 1'b1,1'b0,1'b1,5'b10000,2'b00},
        {8'h00,1'b0,1'b0,5'b01111,1'b1,2'b00,2'b01, 1'b0,1'b0,1'b0,5'b10000,2'b00},
        {8'h01,1'b1,1'b0,5'b00001,1'b0,2'b00,2'b11, 1'b0,1'b1,1'b0,5'b00001,2'b00},
        {8'h00,1'b0,1'b0,5'b00110,1'b0,2'b11,2'b10, 1'b1,1'b1,1'b0,5'b00110,2'b00}
    };

    function automatic string req_of(int i);
        case (i)
            0, 1:   return "R1";
            2:      return "R2";
            3:      return "R3";
            4:      return "R4";
            5, 6, 7: return "R5";
            8, 12:  return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick();
        tick_16k = 1'b1;
        @(negedge clk);
        tick_16k = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        key_cols = 8'hC0; direct_wake_en = 1'b1; six_col_mode = 1'b1;
        irq_mask = 5'h1F; fiq_pin = 1'b1; ext_irq_pin = 2'b11;
        media_pin = 1'b0; tick_16k = 1'b0; pwr_state = 2'b01;
        cycles(5);
        // R10: outputs quiet under reset with inputs active
        chk("R10", "status in reset", raw_status, 0);
        chk("R10", "wake in reset", wake_req, 0);
        chk("R10", "gpio in reset", key_gpio, 0);
        rst = 1'b0;
        key_cols = 8'h00; direct_wake_en = 1'b0; six_col_mode = 1'b0;
        irq_mask = 5'h00; fiq_pin = 1'b0; ext_irq_pin = 2'b00;
        cycles(1);
        chk("R10", "irq after reset", {irq_req, fiq_req}, 0);
        cycles(5);

        for (int v = 0; v < NV; v++) begin
            key_cols       = VEC[v][29:22];
            direct_wake_en = VEC[v][21];
            six_col_mode   = VEC[v][20];
            irq_mask       = VEC[v][19:15];
            fiq_pin        = VEC[v][14];
            ext_irq_pin    = VEC[v][13:12];
            pwr_state      = VEC[v][11:10];
            cycles(6);
            chk(req_of(v), $sformatf("row %0d wake", v), wake_req, VEC[v][9]);
            chk(req_of(v), $sformatf("row %0d irq", v), irq_req, VEC[v][8]);
            chk(req_of(v), $sformatf("row %0d fiq", v), fiq_req, VEC[v][7]);
            chk(req_of(v), $sformatf("row %0d status", v), raw_status, VEC[v][6:2]);
            chk(req_of(v), $sformatf("row %0d gpio", v), key_gpio, VEC[v][1:0]);
        end

        // R6: three-edge latency on an unfiltered pin
        key_cols = 8'h00; fiq_pin = 1'b0; ext_irq_pin = 2'b00;
        six_col_mode = 1'b0; direct_wake_en = 1'b0;
        irq_mask = 5'b01000; pwr_state = 2'b01;
        cycles(6);
        ext_irq_pin = 2'b01;
        cycles(2);
        chk("R6", "ext0 after two edges", raw_status[1], 0);
        cycles(1);
        chk("R6", "ext0 after three edges", raw_status[1], 1);
        ext_irq_pin = 2'b00;
        cycles(4);

        // R7: media filter
        media_pin = 1'b1;
        cycles(4);
        tick();
        cycles(3);
        chk("R7", "media after one high sample", raw_status[3], 0);
        tick();
        cycles(3);
        chk("R7", "media after two high samples", raw_status[3], 1);
        chk("R7", "media irq masked in", irq_req, 1);
        chk("R7", "media wakes in idle", wake_req, 1);
        media_pin = 1'b0;
        cycles(4);
        tick();
        cycles(3);
        chk("R7", "media after one low sample", raw_status[3], 1);
        tick();
        cycles(3);
        chk("R7", "media after two low samples", raw_status[3], 0);
        media_pin = 1'b1;
        cycles(4);
        tick();
        media_pin = 1'b0;
        cycles(4);
        tick();
        cycles(3);
        chk("R7", "media single-sample glitch", raw_status[3], 0);
        media_pin = 1'b1;
        cycles(30);
        chk("R7", "media without strobes", raw_status[3], 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule